// File: doc/BRIEF.md
# Scaled Radix-4 Butterfly Unit

This block is the arithmetic core of a memory-based FFT engine. Each accepted beat carries four complex samples and three twiddle factors. The twiddles rotate the second, third and fourth samples in a first pipeline stage. A second stage combines the four products in a radix-4 decimation-in-time butterfly, divides every result by four with round-half-up, and saturates it to 16 bits. A control bit selects the forward or the inverse rotation. Another control bit reduces the butterfly to a two-point one. Twiddles that equal plus or minus one, or plus or minus i, take an exact path that does not use the multiplier. A pre-shift bit halves the inputs of the first pass.

While a pass runs over the data, the block keeps the smallest number of redundant sign bits seen in any output component. The controller marks the first butterfly of a pass with a start pulse and the last one with an end pulse. When the last outputs appear, the block reports the minimum together with a one-cycle flag. The controller uses this value to choose a block exponent for the next pass.

Top module: `bfly4_core`

## Requirements
- R1: A beat taken with `in_valid` high at one rising edge appears at the outputs after the second rising edge, with `out_valid` high for one cycle. After reset, `out_valid` and `blk_valid` are low, all outputs are zero and `blk_sign` is 15.
- R2: Complex words are packed as {real[31:16], imag[15:0]}, both two's complement. Twiddles are Q1.15 in the same packing. With b=B·Wb, c=C·Wc and d=D·Wd, the forward outputs are X0=A+b+c+d, X1=A−jb−c+jd, X2=A−b+c−d and X3=A+jb−c−jd, each divided by 4.
- R3: With `cfg_inverse` high, X1 and X3 swap their j signs: X1=A+jb−c−jd and X3=A−jb−c+jd. X0 and X2 are unchanged.
- R4: Each output component is floor(exact/4 + 1/2), where the exact value carries full product precision. It is then saturated to the range [−32768, 32767].
- R5: With `cfg_radix2` high, B and D are ignored. The block outputs X0=(A+c)/4 and X1=(A−c)/4, and X2 and X3 are zero.
- R6: The twiddle codes {0x7FFF,0x0000}, {0x8000,0x0000}, {0x0000,0x7FFF} and {0x0000,0x8000} act as exactly +1, −1, +i and −i. This holds even for an input of −32768.
- R7: With `cfg_preshift` high, every input is halved before the butterfly, so the total scale becomes 1/8.
- R8: `blk_sign` is the minimum, over all output components since the last start, of the count of bits below the MSB that equal the MSB (0 to 15). A beat with `stage_start` high restarts the minimum from its own outputs.
- R9: `blk_valid` is high for exactly the output cycle of a beat taken with `stage_end` high.
- R10: When `in_valid` is low, the outputs hold their values and `out_valid` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input beat present |
| stage_start | input | 1 | Beat is the first butterfly of a pass |
| stage_end | input | 1 | Beat is the last butterfly of a pass |
| cfg_radix2 | input | 1 | Two-point butterfly on A and C |
| cfg_inverse | input | 1 | Inverse-transform rotation |
| cfg_preshift | input | 1 | Extra halving of the inputs |
| in_a | input | 32 | Sample A {re, im} |
| in_b | input | 32 | Sample B {re, im} |
| in_c | input | 32 | Sample C {re, im} |
| in_d | input | 32 | Sample D {re, im} |
| tw_b | input | 32 | Twiddle for B, Q1.15 {re, im} |
| tw_c | input | 32 | Twiddle for C, Q1.15 {re, im} |
| tw_d | input | 32 | Twiddle for D, Q1.15 {re, im} |
| out_valid | output | 1 | Output beat present |
| out_x0 | output | 32 | Result X0 {re, im} |
| out_x1 | output | 32 | Result X1 {re, im} |
| out_x2 | output | 32 | Result X2 {re, im} |
| out_x3 | output | 32 | Result X3 {re, im} |
| blk_sign | output | 4 | Running minimum of redundant sign bits |
| blk_valid | output | 1 | Pass minimum is final |

## Verification
The bench builds the block with its defaults: 16-bit data and 16-bit twiddles. At these widths the −32768 corner is reachable, and so is a product magnitude near two, which drives the pre-saturation sum past 16 bits and exercises the clamp. The rounding ties at ±1/2 can be hit with single-digit inputs. The sign-bit counter also spans its full range, from 15 for zero outputs down to small counts for near-full-scale results.

// File: rtl/bfly_pkg.sv
`timescale 1ns/1ps
package bfly_pkg;
    localparam int DEF_DW = 16;
    localparam int DEF_TW = 16;

    typedef enum logic [2:0] {
        TWK_GEN,
        TWK_POS1,
        TWK_NEG1,
        TWK_POSJ,
        TWK_NEGJ
    } tw_kind_e;
endpackage

// File: rtl/bfly_twmul.sv
`timescale 1ns/1ps
// One complex rotation lane: general multiply or exact bypass for unit twiddles.
module bfly_twmul
    import bfly_pkg::*;
#(
    parameter int DW = DEF_DW,
    parameter int TW = DEF_TW,
    localparam int PW = DW + TW + 2
) (
    input  logic signed [DW-1:0] x_re,
    input  logic signed [DW-1:0] x_im,
    input  logic signed [TW-1:0] w_re,
    input  logic signed [TW-1:0] w_im,
    input  logic                 unity,
    input  logic                 preshift,
    output logic signed [PW-1:0] p_re,
    output logic signed [PW-1:0] p_im
);
    localparam int MW = PW - 1;
    localparam logic signed [TW-1:0] W_MAX  = {1'b0, {(TW-1){1'b1}}};
    localparam logic signed [TW-1:0] W_MIN  = {1'b1, {(TW-1){1'b0}}};
    localparam logic signed [TW-1:0] W_ZERO = '0;

    tw_kind_e                kind;
    logic signed [DW+TW-1:0] m_rr, m_ii, m_ri, m_ir;
    logic signed [MW-1:0]    xr_u, xi_u, q_re, q_im;

    always_comb begin
        if (unity)                                  kind = TWK_POS1;
        else if (w_im == W_ZERO && w_re == W_MAX)   kind = TWK_POS1;
        else if (w_im == W_ZERO && w_re == W_MIN)   kind = TWK_NEG1;
        else if (w_re == W_ZERO && w_im == W_MAX)   kind = TWK_POSJ;
        else if (w_re == W_ZERO && w_im == W_MIN)   kind = TWK_NEGJ;
        else                                        kind = TWK_GEN;
    end

    always_comb begin
        m_rr = x_re * w_re;
        m_ii = x_im * w_im;
        m_ri = x_re * w_im;
        m_ir = x_im * w_re;
        // input aligned to the product scale of the Q1.15 twiddle
        xr_u = {{2{x_re[DW-1]}}, x_re, {(TW-1){1'b0}}};
        xi_u = {{2{x_im[DW-1]}}, x_im, {(TW-1){1'b0}}};
        unique case (kind)
            TWK_POS1: begin q_re = xr_u;  q_im = xi_u;  end
            TWK_NEG1: begin q_re = -xr_u; q_im = -xi_u; end
            TWK_POSJ: begin q_re = -xi_u; q_im = xr_u;  end
            TWK_NEGJ: begin q_re = xi_u;  q_im = -xr_u; end
            default: begin
                q_re = {m_rr[DW+TW-1], m_rr} - {m_ii[DW+TW-1], m_ii};
                q_im = {m_ri[DW+TW-1], m_ri} + {m_ir[DW+TW-1], m_ir};
            end
        endcase
        p_re = preshift ? {q_re[MW-1], q_re} : {q_re, 1'b0};
        p_im = preshift ? {q_im[MW-1], q_im} : {q_im, 1'b0};
    end
endmodule

// File: rtl/bfly_combine.sv
`timescale 1ns/1ps
// Radix-4 sums, divide by four, round half up, saturate.
module bfly_combine
    import bfly_pkg::*;
#(
    parameter int DW = DEF_DW,
    parameter int TW = DEF_TW,
    localparam int PW = DW + TW + 2,
    localparam int LANES = 4
) (
    input  logic signed [PW-1:0] p_re [LANES],
    input  logic signed [PW-1:0] p_im [LANES],
    input  logic                 radix2,
    input  logic                 inverse,
    output logic signed [DW-1:0] y_re [LANES],
    output logic signed [DW-1:0] y_im [LANES]
);
    localparam int SW = PW + 2;
    localparam int SH = TW + 2;
    localparam int QW = SW - SH;
    localparam logic signed [SW-1:0] RND  = {{(SW-SH){1'b0}}, 1'b1, {(SH-1){1'b0}}};
    localparam logic signed [QW-1:0] QMAX = {{(QW-DW+1){1'b0}}, {(DW-1){1'b1}}};
    localparam logic signed [QW-1:0] QMIN = {{(QW-DW+1){1'b1}}, {(DW-1){1'b0}}};
    localparam logic signed [DW-1:0] DMAX = {1'b0, {(DW-1){1'b1}}};
    localparam logic signed [DW-1:0] DMIN = {1'b1, {(DW-1){1'b0}}};

    function automatic logic signed [SW-1:0] widen(input logic signed [PW-1:0] v);
        return {{2{v[PW-1]}}, v};
    endfunction

    function automatic logic signed [DW-1:0] shrink(input logic signed [SW-1:0] s);
        logic signed [SW-1:0] r;
        logic signed [QW-1:0] q;
        r = s + RND;
        q = r[SW-1:SH];
        if (q > QMAX)      return DMAX;
        else if (q < QMIN) return DMIN;
        else               return q[DW-1:0];
    endfunction

    logic signed [SW-1:0] ar, ai, br, bi, cr, ci, dr, di;
    logic signed [SW-1:0] t0r, t0i, t1r, t1i, t2r, t2i, t3r, t3i, rr, ri;
    logic signed [SW-1:0] s_re [LANES];
    logic signed [SW-1:0] s_im [LANES];

    always_comb begin
        ar = widen(p_re[0]);
        ai = widen(p_im[0]);
        cr = widen(p_re[2]);
        ci = widen(p_im[2]);
        br = radix2 ? '0 : widen(p_re[1]);
        bi = radix2 ? '0 : widen(p_im[1]);
        dr = radix2 ? '0 : widen(p_re[3]);
        di = radix2 ? '0 : widen(p_im[3]);
        t0r = ar + cr;  t0i = ai + ci;
        t1r = ar - cr;  t1i = ai - ci;
        t2r = br + dr;  t2i = bi + di;
        t3r = br - dr;  t3i = bi - di;
        // rotation of (B-D): -j forward, +j inverse
        rr = inverse ? -t3i : t3i;
        ri = inverse ? t3r  : -t3r;
        s_re[0] = t0r + t2r;  s_im[0] = t0i + t2i;
        s_re[1] = t1r + rr;   s_im[1] = t1i + ri;
        s_re[2] = t0r - t2r;  s_im[2] = t0i - t2i;
        s_re[3] = t1r - rr;   s_im[3] = t1i - ri;
    end

    for (genvar k = 0; k < LANES; k++) begin : g_out
        if (k < 2) begin : g_keep
            assign y_re[k] = shrink(s_re[k]);
            assign y_im[k] = shrink(s_im[k]);
        end else begin : g_gate
            assign y_re[k] = radix2 ? '0 : shrink(s_re[k]);
            assign y_im[k] = radix2 ? '0 : shrink(s_im[k]);
        end
    end
endmodule

// File: rtl/bfly_signcnt.sv
`timescale 1ns/1ps
// Minimum count of redundant sign bits across N components.
module bfly_signcnt
    import bfly_pkg::*;
#(
    parameter int DW = DEF_DW,
    parameter int N  = 8,
    localparam int CW = $clog2(DW)
) (
    input  logic [DW-1:0] v [N],
    output logic [CW-1:0] cmin
);
    function automatic logic [CW-1:0] lead(input logic [DW-1:0] x);
        logic [CW-1:0] n;
        logic          run;
        n   = '0;
        run = 1'b1;
        for (int i = DW - 2; i >= 0; i--) begin
            if (run && x[i] == x[DW-1]) n = n + 1'b1;
            else                        run = 1'b0;
        end
        return n;
    endfunction

    logic [CW-1:0] cnt [N];

    for (genvar i = 0; i < N; i++) begin : g_cnt
        assign cnt[i] = lead(v[i]);
    end

    always_comb begin
        cmin = CW'(DW - 1);
        for (int i = 0; i < N; i++) begin
            if (cnt[i] < cmin) cmin = cnt[i];
        end
    end
endmodule

// File: rtl/bfly4_core.sv
`timescale 1ns/1ps
module bfly4_core
    import bfly_pkg::*;
#(
    parameter int DW = DEF_DW,
    parameter int TW = DEF_TW,
    localparam int PW = DW + TW + 2,
    localparam int CW = $clog2(DW),
    localparam int LANES = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic            stage_start,
    input  logic            stage_end,
    input  logic            cfg_radix2,
    input  logic            cfg_inverse,
    input  logic            cfg_preshift,
    input  logic [2*DW-1:0] in_a,
    input  logic [2*DW-1:0] in_b,
    input  logic [2*DW-1:0] in_c,
    input  logic [2*DW-1:0] in_d,
    input  logic [2*TW-1:0] tw_b,
    input  logic [2*TW-1:0] tw_c,
    input  logic [2*TW-1:0] tw_d,
    output logic            out_valid,
    output logic [2*DW-1:0] out_x0,
    output logic [2*DW-1:0] out_x1,
    output logic [2*DW-1:0] out_x2,
    output logic [2*DW-1:0] out_x3,
    output logic [CW-1:0]   blk_sign,
    output logic            blk_valid
);
    localparam logic [CW-1:0] MAXC = CW'(DW - 1);

    typedef struct packed {
        logic                       v1;
        logic                       st1;
        logic                       en1;
        logic                       r2;
        logic                       inv;
        logic [LANES-1:0][PW-1:0]   pre;
        logic [LANES-1:0][PW-1:0]   pim;
        logic                       v2;
        logic [LANES-1:0][2*DW-1:0] y;
        logic [CW-1:0]              mn;
        logic                       bv;
    } pipe_t;

    pipe_t pipe_d, pipe_q;

    logic signed [DW-1:0] xin_re [LANES];
    logic signed [DW-1:0] xin_im [LANES];
    logic signed [TW-1:0] win_re [LANES];
    logic signed [TW-1:0] win_im [LANES];
    logic signed [PW-1:0] m_re   [LANES];
    logic signed [PW-1:0] m_im   [LANES];
    logic signed [PW-1:0] s1_re  [LANES];
    logic signed [PW-1:0] s1_im  [LANES];
    logic signed [DW-1:0] c_re   [LANES];
    logic signed [DW-1:0] c_im   [LANES];
    logic        [DW-1:0] cv     [2*LANES];
    logic        [CW-1:0] cmin;
    logic        [CW-1:0] mn_base;

    always_comb begin
        xin_re[0] = in_a[2*DW-1:DW];  xin_im[0] = in_a[DW-1:0];
        xin_re[1] = in_b[2*DW-1:DW];  xin_im[1] = in_b[DW-1:0];
        xin_re[2] = in_c[2*DW-1:DW];  xin_im[2] = in_c[DW-1:0];
        xin_re[3] = in_d[2*DW-1:DW];  xin_im[3] = in_d[DW-1:0];
        win_re[0] = '0;               win_im[0] = '0;
        win_re[1] = tw_b[2*TW-1:TW];  win_im[1] = tw_b[TW-1:0];
        win_re[2] = tw_c[2*TW-1:TW];  win_im[2] = tw_c[TW-1:0];
        win_re[3] = tw_d[2*TW-1:TW];  win_im[3] = tw_d[TW-1:0];
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        bfly_twmul #(.DW(DW), .TW(TW)) u_mul (
            .x_re     (xin_re[g]),
            .x_im     (xin_im[g]),
            .w_re     (win_re[g]),
            .w_im     (win_im[g]),
            .unity    ((g == 0) ? 1'b1 : 1'b0),
            .preshift (cfg_preshift),
            .p_re     (m_re[g]),
            .p_im     (m_im[g])
        );
        assign s1_re[g]     = pipe_q.pre[g];
        assign s1_im[g]     = pipe_q.pim[g];
        assign cv[2*g]      = c_re[g];
        assign cv[2*g+1]    = c_im[g];
    end

    bfly_combine #(.DW(DW), .TW(TW)) u_comb (
        .p_re    (s1_re),
        .p_im    (s1_im),
        .radix2  (pipe_q.r2),
        .inverse (pipe_q.inv),
        .y_re    (c_re),
        .y_im    (c_im)
    );

    bfly_signcnt #(.DW(DW), .N(2*LANES)) u_sign (
        .v    (cv),
        .cmin (cmin)
    );

    always_comb begin
        pipe_d     = pipe_q;
        mn_base    = pipe_q.st1 ? MAXC : pipe_q.mn;
        // stage 1: rotations
        pipe_d.v1  = in_valid;
        pipe_d.st1 = in_valid & stage_start;
        pipe_d.en1 = in_valid & stage_end;
        if (in_valid) begin
            pipe_d.r2  = cfg_radix2;
            pipe_d.inv = cfg_inverse;
            for (int k = 0; k < LANES; k++) begin
                pipe_d.pre[k] = m_re[k];
                pipe_d.pim[k] = m_im[k];
            end
        end
        // stage 2: sums, scaling, sign-bit minimum
        pipe_d.v2 = pipe_q.v1;
        pipe_d.bv = pipe_q.v1 & pipe_q.en1;
        if (pipe_q.v1) begin
            for (int k = 0; k < LANES; k++) begin
                pipe_d.y[k] = {c_re[k], c_im[k]};
            end
            pipe_d.mn = (cmin < mn_base) ? cmin : mn_base;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe_q    <= '0;
            pipe_q.mn <= MAXC;
        end else begin
            pipe_q <= pipe_d;
        end
    end

    assign out_valid = pipe_q.v2;
    assign out_x0    = pipe_q.y[0];
    assign out_x1    = pipe_q.y[1];
    assign out_x2    = pipe_q.y[2];
    assign out_x3    = pipe_q.y[3];
    assign blk_sign  = pipe_q.mn;
    assign blk_valid = pipe_q.bv;
endmodule

// File: rtl/bfly4_core_chk.sv
`timescale 1ns/1ps
module bfly4_core_chk #(
    parameter int DW = 16,
    parameter int CW = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            in_valid,
    input logic            cfg_radix2,
    input logic            out_valid,
    input logic [2*DW-1:0] out_x0,
    input logic [2*DW-1:0] out_x1,
    input logic [2*DW-1:0] out_x2,
    input logic [2*DW-1:0] out_x3,
    input logic [CW-1:0]   blk_sign,
    input logic            blk_valid
);
    logic [1:0] age_q;
    logic       warm;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              age_q <= '0;
        else if (age_q != 2'd3)  age_q <= age_q + 2'd1;
    end
    assign warm = age_q[1];

    function automatic int lead(input logic [DW-1:0] x);
        int n;
        n = 0;
        for (int i = DW - 2; i >= 0; i--) begin
            if (x[i] == x[DW-1]) n++;
            else break;
        end
        return n;
    endfunction

    // R1
    valid_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        warm |-> out_valid == $past(in_valid, 2));

    // R10
    hold_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && !$past(in_valid, 2)) |->
            ($stable(out_x0) && $stable(out_x1) && $stable(out_x2) && $stable(out_x3)));

    // R5
    r2_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && $past(in_valid, 2) && $past(cfg_radix2, 2)) |->
            (out_x2 == '0 && out_x3 == '0));

    // R9
    blk_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        blk_valid |-> out_valid);

    // R8
    min_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (int'(blk_sign) <= lead(out_x0[2*DW-1:DW]) &&
                       int'(blk_sign) <= lead(out_x0[DW-1:0])));
endmodule

bind bfly4_core bfly4_core_chk #(.DW(DW), .CW(CW)) u_chk (.*);

// File: tb/bfly4_core_tb.sv
`timescale 1ns/1ps
module bfly4_core_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0, stage_start = 1'b0, stage_end = 1'b0;
    logic        cfg_radix2 = 1'b0, cfg_inverse = 1'b0, cfg_preshift = 1'b0;
    logic [31:0] in_a = '0, in_b = '0, in_c = '0, in_d = '0;
    logic [31:0] tw_b = '0, tw_c = '0, tw_d = '0;
    logic        out_valid, blk_valid;
    logic [31:0] out_x0, out_x1, out_x2, out_x3;
    logic [3:0]  blk_sign;
    logic [31:0] ov [4];

    always #4 clk = ~clk;

    bfly4_core u_dut (.*);

    assign ov[0] = out_x0;
    assign ov[1] = out_x1;
    assign ov[2] = out_x2;
    assign ov[3] = out_x3;

    int     n_chk = 0, n_fail = 0;
    bit     done = 1'b0;
    longint e_re [4];
    longint e_im [4];
    int     mn_exp = 15;

    task automatic check(string tag, longint act, longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] cx(int re, int im);
        return {re[15:0], im[15:0]};
    endfunction

    function automatic longint sre(logic [31:0] w); return longint'($signed(w[31:16])); endfunction
    function automatic longint sim(logic [31:0] w); return longint'($signed(w[15:0])); endfunction

    function automatic int nlead(logic [15:0] x);
        int n = 0;
        for (int i = 14; i >= 0; i--) begin
            if (x[i] == x[15]) n++;
            else break;
        end
        return n;
    endfunction

    task automatic rot(input logic [31:0] x, input logic [31:0] w, output longint pr, output longint pi);
        longint xr = sre(x), xi = sim(x), wr = sre(w), wi = sim(w);
        if (w == 32'h7FFF_0000)      begin pr = xr * 32768;  pi = xi * 32768;  end
        else if (w == 32'h8000_0000) begin pr = -xr * 32768; pi = -xi * 32768; end
        else if (w == 32'h0000_7FFF) begin pr = -xi * 32768; pi = xr * 32768;  end
        else if (w == 32'h0000_8000) begin pr = xi * 32768;  pi = -xr * 32768; end
        else begin pr = xr * wr - xi * wi; pi = xr * wi + xi * wr; end
    endtask

    function automatic longint fin(longint s);
        longint q = (s + 131072) >>> 18;
        if (q > 32767) q = 32767;
        if (q < -32768) q = -32768;
        return q;
    endfunction

    task automatic model(input logic [31:0] a, b, c, d, wb, wc, wd, input bit r2, inv, ps);
        longint k = ps ? 1 : 2;
        longint ar, ai, br, bi, cr, ci, dr, di, jr, ji;
        ar = sre(a) * 32768; ai = sim(a) * 32768;
        rot(b, wb, br, bi); rot(c, wc, cr, ci); rot(d, wd, dr, di);
        if (r2) begin br = 0; bi = 0; dr = 0; di = 0; end
        ar *= k; ai *= k; br *= k; bi *= k; cr *= k; ci *= k; dr *= k; di *= k;
        // j*(B-D)
        jr = -(bi - di); ji = br - dr;
        e_re[0] = fin(ar + br + cr + dr); e_im[0] = fin(ai + bi + ci + di);
        e_re[2] = fin(ar - br + cr - dr); e_im[2] = fin(ai - bi + ci - di);
        if (!inv) begin
            e_re[1] = fin(ar - cr - jr); e_im[1] = fin(ai - ci - ji);
            e_re[3] = fin(ar - cr + jr); e_im[3] = fin(ai - ci + ji);
        end else begin
            e_re[1] = fin(ar - cr + jr); e_im[1] = fin(ai - ci + ji);
            e_re[3] = fin(ar - cr - jr); e_im[3] = fin(ai - ci - ji);
        end
        if (r2) begin e_re[2] = 0; e_im[2] = 0; e_re[3] = 0; e_im[3] = 0; end
    endtask

    // drives one beat, waits two edges, checks all outputs and the block minimum
    task automatic fire(input logic [31:0] a, b, c, d, wb, wc, wd,
                        input bit r2, inv, ps, st, en, input string tag);
        int cur = 15;
        model(a, b, c, d, wb, wc, wd, r2, inv, ps);
        for (int k = 0; k < 4; k++) begin
            if (nlead(e_re[k][15:0]) < cur) cur = nlead(e_re[k][15:0]);
            if (nlead(e_im[k][15:0]) < cur) cur = nlead(e_im[k][15:0]);
        end
        mn_exp = st ? cur : ((cur < mn_exp) ? cur : mn_exp);
        @(negedge clk);
        in_a = a; in_b = b; in_c = c; in_d = d;
        tw_b = wb; tw_c = wc; tw_d = wd;
        cfg_radix2 = r2; cfg_inverse = inv; cfg_preshift = ps;
        stage_start = st; stage_end = en; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0; stage_start = 1'b0; stage_end = 1'b0;
        @(negedge clk);
        check({tag, " R1 out_valid"}, out_valid, 1);
        for (int k = 0; k < 4; k++) begin
            check($sformatf("%s X%0d.re", tag, k), sre(ov[k]), e_re[k]);
            check($sformatf("%s X%0d.im", tag, k), sim(ov[k]), e_im[k]);
        end
        check({tag, " R8 blk_sign"}, blk_sign, mn_exp);
        check({tag, " R9 blk_valid"}, blk_valid, en);
    endtask

    task automatic t_reset();
        check("R1 reset out_valid", out_valid, 0);
        check("R1 reset out_x0", out_x0, 0);
        check("R1 reset out_x3", out_x3, 0);
        check("R9 reset blk_valid", blk_valid, 0);
        check("R8 reset blk_sign", blk_sign, 15);
    endtask

    task automatic t_forward();
        fire(cx(4000, 0), 0, 0, 0, cx(1234, -777), cx(5, 5), cx(-9, 3), 0, 0, 0, 0, 0, "R2 dc");
        check("R2 dc X1.re", sre(out_x1), 1000);
        check("R2 dc X3.re", sre(out_x3), 1000);
        fire(cx(1000, -2000), cx(3000, 500), cx(-1500, 2500), cx(700, -300),
             cx(23170, -23170), cx(30274, -12540), cx(12540, -30274), 0, 0, 0, 0, 0, "R2 mix");
        fire(cx(-20000, 15000), cx(12000, 12000), cx(-8000, 30000), cx(25000, -25000),
             cx(-12540, -30274), cx(-23170, 23170), cx(32767, 1), 0, 0, 0, 0, 0, "R2 wide");
    endtask

    task automatic t_inverse();
        fire(cx(1000, -2000), cx(3000, 500), cx(-1500, 2500), cx(700, -300),
             cx(23170, -23170), cx(30274, -12540), cx(12540, -30274), 0, 1, 0, 0, 0, "R3 mix");
        fire(0, cx(4000, 0), 0, 0, 32'h7FFF_0000, 0, 0, 0, 1, 0, 0, 0, "R3 unitB");
        check("R3 X1 is +jB/4 im", sim(out_x1), 1000);
        check("R3 X1 is +jB/4 re", sre(out_x1), 0);
    endtask

    task automatic t_round();
        fire(cx(2, 0), 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R4 half");
        check("R4 +1/2 rounds up", sre(out_x0), 1);
        fire(cx(1, 0), 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R4 quarter");
        check("R4 +1/4 rounds to 0", sre(out_x0), 0);
        fire(cx(-2, -3), 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R4 neg");
        check("R4 -1/2 rounds to 0", sre(out_x0), 0);
        check("R4 -3/4 rounds to -1", sim(out_x0), -1);
        fire(cx(32767, 0), cx(-32768, -32768), cx(-32768, -32768), cx(-32768, -32768),
             cx(-32768, 32767), cx(-32768, 32767), cx(-32768, 32767), 0, 0, 0, 0, 0, "R4 sat");
        check("R4 saturate high", sre(out_x0), 32767);
    endtask

    task automatic t_radix2();
        fire(cx(400, 0), cx(9999, -9999), cx(400, 0), cx(-7777, 5555),
             cx(100, 100), 32'h7FFF_0000, cx(-300, 20), 1, 0, 0, 0, 0, "R5 unit");
        check("R5 X0 (A+C)/4", sre(out_x0), 200);
        check("R5 X1 (A-C)/4", sre(out_x1), 0);
        fire(cx(-3000, 1700), cx(5000, 5000), cx(2200, -900), cx(3000, 3000),
             cx(1, 2), cx(23170, -23170), cx(3, 4), 1, 1, 0, 0, 0, "R5 gen");
    endtask

    task automatic t_trivial();
        fire(0, cx(-32768, 0), 0, 0, 32'h8000_0000, 0, 0, 0, 0, 0, 0, 0, "R6 neg1");
        check("R6 -1 times -32768", sre(out_x0), 8192);
        fire(cx(100, 200), cx(-32768, 32767), cx(-32768, -32768), cx(12345, -32768),
             32'h7FFF_0000, 32'h0000_7FFF, 32'h0000_8000, 0, 0, 0, 0, 0, "R6 codes");
        fire(0, 0, cx(0, -32768), 0, 0, 32'h0000_7FFF, 0, 0, 0, 0, 0, 0, "R6 posj");
        check("R6 +i times -32768i", sre(out_x0), 8192);
    endtask

    task automatic t_preshift();
        fire(cx(4000, 0), 0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0, "R7 dc");
        check("R7 A/8", sre(out_x0), 500);
        fire(cx(1000, -2000), cx(3000, 500), cx(-1500, 2500), cx(700, -300),
             cx(23170, -23170), cx(30274, -12540), cx(12540, -30274), 0, 0, 1, 0, 0, "R7 mix");
    endtask

    task automatic t_blockfp();
        fire(cx(40, 0), 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0, "R8 first");
        fire(cx(32000, 0), 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R8 mid");
        fire(cx(80, 0), 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, "R9 last");
        check("R8 pass minimum", blk_sign, 2);
        @(negedge clk);
        check("R9 flag single cycle", blk_valid, 0);
        fire(cx(40, 0), 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 1, "R8 restart");
        check("R8 restart minimum", blk_sign, 11);
    endtask

    task automatic t_hold();
        logic [31:0] keep;
        fire(cx(1000, -2000), cx(3000, 500), cx(-1500, 2500), cx(700, -300),
             cx(23170, -23170), cx(30274, -12540), cx(12540, -30274), 0, 0, 0, 0, 0, "R10 base");
        keep = out_x1;
        @(negedge clk);
        in_a = cx(-5, 5); in_b = cx(7, 7); tw_b = cx(100, 100); cfg_inverse = 1'b1;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check("R10 out_valid low", out_valid, 0);
            check("R10 X1 held", out_x1, keep);
        end
        cfg_inverse = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_forward();
        t_inverse();
        t_round();
        t_radix2();
        t_trivial();
        t_preshift();
        t_blockfp();
        t_hold();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end
endmodule